// File: doc/BRIEF.md
# Low-Power Clock Source Switch Controller

This controller chooses which of three clock sources drives the core: a primary oscillator, an internal RC oscillator, or a 32.768 kHz secondary oscillator. Software writes a two-bit select value. The controller makes that value legal against the secondary-oscillator enable input. If the legal value differs from the one already held, the controller starts a switch.

Every source arrives as a one-cycle tick, and one fast reference clock samples all of them. Each tick stands for one falling edge of that source. During a switch, the four-phase core clock stays in Q1 until the newly selected source has produced eight ticks. The controller then releases the phase generator and updates its status flags. The controller also asks the primary oscillator to shut down while the secondary source is selected.

Top module: `lpclk_switch`

## Requirements
- R1: After synchronous reset, the outputs are as follows: `selState` is 00, `phase` is 0 (Q1), and `coreHold`, `instrAdv`, `priShutdown`, `secRunning` and `startDone` are all 0.
- R2: A write stores the legal value {data[1], data[0] AND secEnable} in `selState`. Select encoding: 00 is the primary source, 10 is the RC source, and x1 (01 or 11) is the secondary source. With `secEnable` low, a requested 01 becomes 00 and a requested 11 becomes 10.
- R3: A write whose legal value equals the held `selState` causes no switch. `coreHold`, `priShutdown`, `secRunning`, `startDone` and `selState` all keep their values.
- R4: A switch to an x1 value clears `startDone` and sets `priShutdown` in the cycle after the write. A switch to 00 or 10 clears `priShutdown` in the cycle after the write.
- R5: From the cycle after a switching write, `coreHold` is 1 and `phase` is 0 (Q1). This lasts until the eighth tick of the newly selected source, and `coreHold` is 0 in the cycle after that eighth tick. Ticks from the other sources do not count.
- R6: Every switch clears `secRunning`. On release, `secRunning` becomes 1 if an x1 value is selected and stays 0 otherwise. A release with 00 selected sets `startDone`. A release with 10 selected leaves `startDone` unchanged.
- R7: A switching write that arrives during the hold restarts the eight-tick count toward the newly legalized target.
- R8: Outside the hold, each tick of the selected source steps `phase` through 0, 1, 2, 3 and back to 0, where 0 is Q1 and 3 is Q4. Ticks from other sources are ignored. The tick that wraps 3 to 0 makes `instrAdv` high for exactly one cycle. The releasing tick leaves `phase` at Q1, so reaching Q2 takes one more tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| selWrEn | input | 1 | Write strobe for the select value |
| selWrData | input | 2 | Requested select value |
| secEnable | input | 1 | Secondary oscillator enabled |
| srcTick | input | 3 | Falling-edge ticks: bit 0 primary, bit 1 RC, bit 2 secondary |
| selState | output | 2 | Legal select value currently held |
| priShutdown | output | 1 | Request to power down the primary oscillator |
| phase | output | 2 | Core clock phase, 0 = Q1 through 3 = Q4 |
| coreHold | output | 1 | Phase generator frozen while a switch is in progress |
| instrAdv | output | 1 | One-cycle pulse at each completed instruction cycle |
| secRunning | output | 1 | Secondary oscillator is the system clock |
| startDone | output | 1 | Oscillator start-up complete flag |

## Verification
Every output is registered, so each result is due exactly one reference cycle after the edge that captures the stimulus. For a write, that edge captures the strobe; for the hold release, the eighth qualifying tick; for phase and `instrAdv`, the tick of the selected source. The bench drives each strobe or tick for one cycle between falling edges and samples at the falling edge right after the capturing rising edge. It looks one extra cycle later to confirm that `instrAdv` has fallen again. Each hold is checked after seven qualifying ticks, with foreign ticks mixed in, and again right after the eighth, which pins the release to a single cycle.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;

  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_RC  = 2'd1,
    SRC_SEC = 2'd2
  } srcId_t;

  typedef struct packed {
    logic       switchEv;
    logic [1:0] newSel;
    logic       holdActive;
  } ctrlStrobe_t;

  function automatic srcId_t decodeSel(input logic [1:0] sel);
    if (sel[0])      return SRC_SEC;
    else if (sel[1]) return SRC_RC;
    else             return SRC_PRI;
  endfunction

  function automatic logic [1:0] legalize(input logic [1:0] req, input logic secEn);
    return {req[1], req[0] & secEn};
  endfunction

endpackage

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl
  import lpclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        selWrEn,
  input  logic [1:0]  selWrData,
  input  logic        secEnable,
  input  logic [1:0]  selReg,
  input  logic        edgeDone,
  output ctrlStrobe_t strobe,
  output logic        secRunning,
  output logic        startDone,
  output logic        priShutdown
);

  logic [1:0] legalSel;
  logic       switchEv;
  logic       holding;

  always_comb begin
    legalSel = legalize(selWrData, secEnable);
    switchEv = selWrEn && (legalSel != selReg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holding     <= 1'b0;
      secRunning  <= 1'b0;
      startDone   <= 1'b0;
      priShutdown <= 1'b0;
    end else if (switchEv) begin
      holding    <= 1'b1;
      secRunning <= 1'b0;
      if (legalSel[0]) begin
        startDone   <= 1'b0;
        priShutdown <= 1'b1;
      end else begin
        priShutdown <= 1'b0;
      end
    end else if (edgeDone) begin
      holding <= 1'b0;
      if (selReg[0])       secRunning <= 1'b1;
      else if (!selReg[1]) startDone  <= 1'b1;
    end
  end

  always_comb begin
    strobe.switchEv   = switchEv;
    strobe.newSel     = legalSel;
    strobe.holdActive = holding;
  end

  // R2: with the enable low, the stored value never selects the secondary source
  assert_legal_sel_R2: assert property (@(posedge clk) disable iff (rst)
    (selWrEn && !secEnable) |=> !selReg[0]);

  // R3: a write that matches the held value starts no hold
  assert_no_switch_R3: assert property (@(posedge clk) disable iff (rst)
    (selWrEn && (legalSel == selReg) && !holding) |=> !holding);

  // R4: the secondary source running implies the primary is asked to stop
  assert_shutdown_R4: assert property (@(posedge clk) disable iff (rst)
    secRunning |-> priShutdown);

  // R6: a release without a new switch ends the hold
  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    (edgeDone && !switchEv) |=> !holding);

endmodule

// File: rtl/lpclk_datapath.sv
module lpclk_datapath
  import lpclk_pkg::*;
#(
  parameter  int EDGE_COUNT = 8,
  parameter  int PHASES     = 4,
  localparam int CNT_W      = (EDGE_COUNT > 1) ? $clog2(EDGE_COUNT) : 1,
  localparam int PH_W       = $clog2(PHASES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcTick,
  input  ctrlStrobe_t        strobe,
  output logic [1:0]         selReg,
  output logic [PH_W-1:0]    phase,
  output logic               instrAdv,
  output logic               edgeDone
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(EDGE_COUNT - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PHASES - 1);

  logic [NUM_SRC-1:0] tickMask;
  logic               curTick;
  logic [CNT_W-1:0]   edgeCnt;
  srcId_t             activeSrc;

  assign activeSrc = decodeSel(selReg);

  for (genvar g = 0; g < NUM_SRC; g++) begin : gTickSel
    assign tickMask[g] = srcTick[g] && (int'(activeSrc) == g);
  end

  assign curTick  = |tickMask;
  assign edgeDone = strobe.holdActive && !strobe.switchEv && curTick && (edgeCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      selReg   <= 2'b00;
      edgeCnt  <= '0;
      phase    <= '0;
      instrAdv <= 1'b0;
    end else begin
      instrAdv <= 1'b0;
      if (strobe.switchEv) begin
        selReg  <= strobe.newSel;
        edgeCnt <= '0;
        phase   <= '0;
      end else if (strobe.holdActive) begin
        if (curTick) edgeCnt <= edgeDone ? '0 : edgeCnt + 1'b1;
      end else if (curTick) begin
        phase    <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        instrAdv <= (phase == PH_LAST);
      end
    end
  end

  // R5: the phase generator stays in Q1 throughout the hold
  assert_hold_q1_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.holdActive |-> (phase == '0));

  // R7: a switch restarts the edge count
  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    strobe.switchEv |=> (edgeCnt == '0));

  // R8: outside the hold, each selected tick steps the phase by one
  assert_phase_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!strobe.holdActive && !strobe.switchEv && curTick) |=>
      (phase == (($past(phase) == PH_LAST) ? '0 : $past(phase) + 1'b1)));

  // R8: an instruction pulse coincides with the return to Q1
  assert_adv_q1_R8: assert property (@(posedge clk) disable iff (rst)
    instrAdv |-> (phase == '0));

endmodule

// File: rtl/lpclk_switch.sv
module lpclk_switch
  import lpclk_pkg::*;
#(
  parameter  int EDGE_COUNT = 8,
  parameter  int PHASES     = 4,
  localparam int PH_W       = $clog2(PHASES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               selWrEn,
  input  logic [1:0]         selWrData,
  input  logic               secEnable,
  input  logic [NUM_SRC-1:0] srcTick,
  output logic [1:0]         selState,
  output logic               priShutdown,
  output logic [PH_W-1:0]    phase,
  output logic               coreHold,
  output logic               instrAdv,
  output logic               secRunning,
  output logic               startDone
);

  ctrlStrobe_t strobe;
  logic        edgeDone;
  logic [1:0]  selReg;

  lpclk_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .selWrEn     (selWrEn),
    .selWrData   (selWrData),
    .secEnable   (secEnable),
    .selReg      (selReg),
    .edgeDone    (edgeDone),
    .strobe      (strobe),
    .secRunning  (secRunning),
    .startDone   (startDone),
    .priShutdown (priShutdown)
  );

  lpclk_datapath #(
    .EDGE_COUNT (EDGE_COUNT),
    .PHASES     (PHASES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .srcTick  (srcTick),
    .strobe   (strobe),
    .selReg   (selReg),
    .phase    (phase),
    .instrAdv (instrAdv),
    .edgeDone (edgeDone)
  );

  assign selState = selReg;
  assign coreHold = strobe.holdActive;

endmodule

// File: tb/sim_lpclk_switch.sv
module sim_lpclk_switch;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       selWrEn = 1'b0;
  logic [1:0] selWrData = 2'b00;
  logic       secEnable = 1'b0;
  logic [2:0] srcTick = 3'b000;
  logic [1:0] selState;
  logic       priShutdown;
  logic [1:0] phase;
  logic       coreHold;
  logic       instrAdv;
  logic       secRunning;
  logic       startDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lpclk_switch u0 (
    .clk(clk), .rst(rst), .selWrEn(selWrEn), .selWrData(selWrData),
    .secEnable(secEnable), .srcTick(srcTick), .selState(selState),
    .priShutdown(priShutdown), .phase(phase), .coreHold(coreHold),
    .instrAdv(instrAdv), .secRunning(secRunning), .startDone(startDone)
  );

  // {secEnable, writeData[1:0], expectedSel[1:0], expectSwitch}
  localparam logic [5:0] VEC [0:8] = '{
    {1'b0, 2'b01, 2'b00, 1'b0},
    {1'b0, 2'b11, 2'b10, 1'b1},
    {1'b1, 2'b11, 2'b11, 1'b1},
    {1'b1, 2'b01, 2'b01, 1'b1},
    {1'b1, 2'b01, 2'b01, 1'b0},
    {1'b0, 2'b01, 2'b00, 1'b1},
    {1'b1, 2'b10, 2'b10, 1'b1},
    {1'b0, 2'b10, 2'b10, 1'b0},
    {1'b0, 2'b00, 2'b00, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tickSrc(input int s);
    @(negedge clk);
    srcTick = 3'(1 << s);
    @(negedge clk);
    srcTick = 3'b000;
  endtask

  task automatic writeSel(input logic en, input logic [1:0] d);
    @(negedge clk);
    secEnable = en;
    selWrData = d;
    selWrEn   = 1'b1;
    @(negedge clk);
    selWrEn   = 1'b0;
  endtask

  function automatic int srcOf(input logic [1:0] s);
    return s[0] ? 2 : (s[1] ? 1 : 0);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic expShut, expRun, expDone;
    expShut = 0; expRun = 0; expDone = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sel", selState, 0);
    check("R1 phase", phase, 0);
    check("R1 hold", coreHold, 0);
    check("R1 adv", instrAdv, 0);
    check("R1 shutdown", priShutdown, 0);
    check("R1 secRunning", secRunning, 0);
    check("R1 startDone", startDone, 0);

    for (int i = 0; i < 9; i++) begin
      logic [1:0] eSel;
      logic       eSw;
      eSel = VEC[i][2:1];
      eSw  = VEC[i][0];
      writeSel(VEC[i][5], VEC[i][4:3]);
      check("R2 legal sel", selState, eSel);
      if (eSw) begin
        expShut = eSel[0];
        expRun  = 0;
        if (eSel[0]) expDone = 0;
        check("R5 hold start", coreHold, 1);
        check("R5 phase Q1", phase, 0);
        check("R4 shutdown", priShutdown, expShut);
        check("R4 startDone", startDone, expDone);
        check("R6 secRunning cleared", secRunning, 0);
        for (int k = 0; k < 7; k++) begin
          tickSrc(srcOf(eSel));
          tickSrc((srcOf(eSel) + 1) % 3);
        end
        check("R5 still held", coreHold, 1);
        check("R5 phase held", phase, 0);
        tickSrc(srcOf(eSel));
        expRun = eSel[0];
        if (eSel == 2'b00) expDone = 1;
        check("R5 release", coreHold, 0);
        check("R6 secRunning", secRunning, expRun);
        check("R6 startDone", startDone, expDone);
      end else begin
        check("R3 no hold", coreHold, 0);
        check("R3 shutdown kept", priShutdown, expShut);
        check("R3 secRunning kept", secRunning, expRun);
        check("R3 startDone kept", startDone, expDone);
      end
    end

    // phase sequencing on the primary source
    tickSrc(1);
    check("R8 foreign tick ignored", phase, 0);
    tickSrc(0); check("R8 Q2", phase, 1);
    tickSrc(0); check("R8 Q3", phase, 2);
    tickSrc(0); check("R8 Q4", phase, 3); check("R8 no adv", instrAdv, 0);
    tickSrc(0); check("R8 wrap", phase, 0); check("R8 adv pulse", instrAdv, 1);
    @(negedge clk);
    check("R8 adv one cycle", instrAdv, 0);

    // restart during hold
    writeSel(1'b1, 2'b11);
    check("R7 hold on secondary", coreHold, 1);
    repeat (5) tickSrc(2);
    writeSel(1'b1, 2'b10);
    check("R7 sel retarget", selState, 2);
    check("R4 shutdown off", priShutdown, 0);
    repeat (7) tickSrc(1);
    check("R7 restarted count holds", coreHold, 1);
    tickSrc(1);
    check("R7 release after eight", coreHold, 0);
    check("R6 not secondary", secRunning, 0);
    check("R8 release stays Q1", phase, 0);
    tickSrc(1);
    check("R8 Q2 after delay", phase, 1);

    // reset mid-run
    writeSel(1'b1, 2'b01);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 sel after reset", selState, 0);
    check("R1 hold after reset", coreHold, 0);
    check("R1 shutdown after reset", priShutdown, 0);
    check("R1 phase after reset", phase, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule